// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a simple synchronous host port and an external asynchronous static memory of 131,072 words by 16 bits. Each of the two byte lanes has its own active-low enable. The host raises a request together with an address, write data, a two-bit lane mask and a direction flag. It holds the request until a one-cycle done pulse comes back, and it lowers the request in the cycle where it sees that pulse. Read data is returned in a registered result word.

All memory timing comes from counted clock cycles. The read access length, the write pulse width and the recovery interval are parameters given in clock cycles. Every access follows the same order. First the address is set while all strobes are high. Then the selected lane enables and one of the two strobes are held low for the counted length. Then all strobes return high together for the recovery interval. The data bus is split into an output word, a per-lane output enable and an input word, so the pad tri-state can be built at the chip edge.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After a synchronous reset, mem_we_n, mem_oe_n and both lane enables are high, mem_dq_oe is 00, host_done is 0 and host_rdata is 0.
- R2: A read holds mem_oe_n low and mem_we_n high for exactly ACC_CYC cycles. host_rdata takes the value sampled on mem_dq_in in the last of those cycles.
- R3: Mask bit 1 selects the upper lane (bits 15:8, enable mem_lane_en_n[1]) and mask bit 0 selects the lower lane (bits 7:0, enable mem_lane_en_n[0]). Only the enables of selected lanes go low. On a read, the bits of an unselected lane return 0.
- R4: A write holds mem_we_n low for exactly WP_CYC cycles with mem_oe_n high. The write data is presented on mem_dq_out, and mem_dq_oe equals the mask during that time.
- R5: mem_addr shows the request address for at least one cycle before any lane enable goes low. It then stays unchanged until all enables are high again.
- R6: Between the end of one access and the next falling lane enable, all enables and mem_we_n stay high for at least REC_CYC+1 cycles.
- R7: host_done is high for exactly one cycle. It comes N+2 cycles after the request is taken, where N is ACC_CYC for a read and WP_CYC for a write.
- R8: A request with mask 00 drives no strobe low. It still completes with done after the same latency, and if it is a read it returns 0.
- R9: host_rdata changes only when a read completes. A write leaves it holding the previous read result.
- R10: mem_oe_n and mem_we_n are never low together, and mem_dq_oe is non-zero only while mem_we_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request, held until host_done |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane select, bit 1 upper, bit 0 lower |
| host_rdata | output | 16 | Registered read result |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | Memory address |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_en_n | output | 2 | Lane enables, bit 1 upper, bit 0 lower, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The memory model in the bench returns a garbage pattern until the read has been low for ACC_CYC cycles, and a fixed pattern on lanes it does not drive. A controller that samples one cycle early, or that fails to zero an unselected lane, therefore returns a visibly wrong word. Partial-lane writes followed by reads of the other lane catch a swapped or ignored enable, because the neighbouring byte would be corrupted. Mask 00 requests confirm that no strobe moves while done still arrives. Writes placed between reads show whether the result register is wrongly overwritten. The model also measures every pulse width, the address hold while enables are low, and the high-time gap between accesses, so a shortened recovery or a bus driven outside the write strobe is reported at the pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sram_seq.sv
// Access sequencer: counts strobe and recovery windows in clock cycles.
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic host_req,
  input  logic host_write,
  output logic go_setup,
  output logic go_active,
  output logic go_end,
  output logic done
);
  localparam int MAX_AW  = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int MAX_CYC = (MAX_AW > REC_CYC) ? MAX_AW : REC_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACC_LAST = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_q;
  logic             done_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt  = wr_q ? WP_LAST : ACC_LAST;
  assign go_setup  = (state_q == ST_IDLE) && host_req;
  assign go_active = (state_q == ST_SETUP);
  assign go_end    = (state_q == ST_ACTIVE) && (cnt_q == last_cnt);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= go_end;
      case (state_q)
        ST_IDLE: begin
          if (host_req) begin
            state_q <= ST_SETUP;
            wr_q    <= host_write;
          end
        end
        ST_SETUP: begin
          state_q <= ST_ACTIVE;
          cnt_q   <= '0;
        end
        ST_ACTIVE: begin
          if (go_end) begin
            state_q <= ST_RECOVER;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RECOVER: begin
          if (cnt_q == REC_LAST) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R7
  done_follows_active_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(state_q) == ST_ACTIVE));
endmodule

// File: rtl/sram_pin_drv.sv
// Registered memory-side pins: address, strobes, lane enables, data drive.
module sram_pin_drv #(
  parameter int ADDR_W  = 17,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int REC_CYC = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic                      strobe_on,
  input  logic                      strobe_off,
  input  logic [ADDR_W-1:0]         in_addr,
  input  logic [LANES*LANE_W-1:0]   in_wdata,
  input  logic [LANES-1:0]          in_mask,
  input  logic                      in_write,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_we_n,
  output logic                      mem_oe_n,
  output logic [LANES-1:0]          mem_lane_en_n,
  output logic [LANES*LANE_W-1:0]   mem_dq_out,
  output logic [LANES-1:0]          mem_dq_oe,
  output logic [LANES-1:0]          mask_q,
  output logic                      write_q
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int GAP_W  = $clog2(REC_CYC + 2) + 1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(REC_CYC + 1);

  logic             any_lane;
  logic [GAP_W-1:0] gap_q;

  assign any_lane = |mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr      <= '0;
      mem_dq_out    <= '0;
      mask_q        <= '0;
      write_q       <= 1'b0;
      mem_we_n      <= 1'b1;
      mem_oe_n      <= 1'b1;
      mem_lane_en_n <= '1;
      mem_dq_oe     <= '0;
    end else begin
      if (load) begin
        mem_addr   <= in_addr;
        mem_dq_out <= in_wdata;
        mask_q     <= in_mask;
        write_q    <= in_write;
      end
      if (strobe_on && any_lane) begin
        mem_lane_en_n <= ~mask_q;
        if (write_q) begin
          mem_we_n  <= 1'b0;
          mem_dq_oe <= mask_q;
        end else begin
          mem_oe_n  <= 1'b0;
        end
      end else if (strobe_off) begin
        mem_lane_en_n <= '1;
        mem_we_n      <= 1'b1;
        mem_oe_n      <= 1'b1;
        mem_dq_oe     <= '0;
      end
    end
  end

  // High-time gap tracker, used only by the recovery check below.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GAP_MIN;
    end else if ((&mem_lane_en_n) && mem_we_n) begin
      if (gap_q != GAP_MIN) gap_q <= gap_q + 1'b1;
    end else begin
      gap_q <= '0;
    end
  end

  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R10
  drive_only_we_chk: assert property (@(posedge clk) disable iff (rst)
    (|mem_dq_oe) |-> !mem_we_n);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&mem_lane_en_n) && !$past(&mem_lane_en_n)) |-> $stable(mem_addr));

  // R6
  recovery_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(&mem_lane_en_n) |-> (gap_q >= GAP_MIN));

  // R3
  write_lane_match_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe == ~mem_lane_en_n));

  // R4
  write_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_out));

  logic unused_width;
  assign unused_width = (DATA_W == 0);
endmodule

// File: rtl/sram_rd_capture.sv
// Per-lane read result register; unselected lanes load zero.
module sram_rd_capture #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cap,
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lane_q <= '0;
      end else if (cap) begin
        lane_q <= mask[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_q;

    // R3
    unsel_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cap && !mask[g]) |=> (lane_q == '0));
  end

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(rdata));
endmodule

// File: rtl/sram_byte_ctrl.sv
// Top: host request port to byte-lane asynchronous SRAM pins.
module sram_byte_ctrl #(
  parameter int ADDR_W  = 17,
  parameter int LANES   = 2,
  parameter int LANE_W  = 8,
  parameter int ACC_CYC = 3,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_req,
  input  logic                     host_write,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [LANES*LANE_W-1:0]  host_wdata,
  input  logic [LANES-1:0]         host_mask,
  output logic [LANES*LANE_W-1:0]  host_rdata,
  output logic                     host_done,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_we_n,
  output logic                     mem_oe_n,
  output logic [LANES-1:0]         mem_lane_en_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  output logic [LANES-1:0]         mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]  mem_dq_in
);
  localparam int DATA_W = LANES * LANE_W;

  logic              go_setup;
  logic              go_active;
  logic              go_end;
  logic [LANES-1:0]  mask_q;
  logic              write_q;
  logic              cap_read;
  logic [DATA_W-1:0] rdata;

  sram_seq #(
    .ACC_CYC (ACC_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC)
  ) i_seq (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_write (host_write),
    .go_setup   (go_setup),
    .go_active  (go_active),
    .go_end     (go_end),
    .done       (host_done)
  );

  sram_pin_drv #(
    .ADDR_W  (ADDR_W),
    .LANES   (LANES),
    .LANE_W  (LANE_W),
    .REC_CYC (REC_CYC)
  ) i_pins (
    .clk           (clk),
    .rst           (rst),
    .load          (go_setup),
    .strobe_on     (go_active),
    .strobe_off    (go_end),
    .in_addr       (host_addr),
    .in_wdata      (host_wdata),
    .in_mask       (host_mask),
    .in_write      (host_write),
    .mem_addr      (mem_addr),
    .mem_we_n      (mem_we_n),
    .mem_oe_n      (mem_oe_n),
    .mem_lane_en_n (mem_lane_en_n),
    .mem_dq_out    (mem_dq_out),
    .mem_dq_oe     (mem_dq_oe),
    .mask_q        (mask_q),
    .write_q       (write_q)
  );

  assign cap_read = go_end && !write_q;

  sram_rd_capture #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) i_cap (
    .clk   (clk),
    .rst   (rst),
    .cap   (cap_read),
    .mask  (mask_q),
    .dq_in (mem_dq_in),
    .rdata (rdata)
  );

  assign host_rdata = rdata;

  // R8
  empty_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> ((&mem_lane_en_n) && mem_we_n && mem_oe_n));

  // R2
  read_data_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_read && (mask_q != '0)) |-> !mem_oe_n);
endmodule

// File: tb/test_sram_byte_ctrl.sv
`timescale 1ns/1ps
module test_sram_byte_ctrl;
  localparam int ADDR_W  = 17;
  localparam int ACC_CYC = 3;
  localparam int WP_CYC  = 2;
  localparam int REC_CYC = 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_write = 1'b0;
  logic [16:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_mask = '0;
  logic [15:0] host_rdata;
  logic        host_done;
  logic [16:0] mem_addr;
  logic        mem_we_n;
  logic        mem_oe_n;
  logic [1:0]  mem_lane_en_n;
  logic [15:0] mem_dq_out;
  logic [1:0]  mem_dq_oe;
  logic [15:0] mem_dq_in = 16'hC3C3;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct {
    bit          is_wr;
    logic [15:0] exp;
  } sb_item_t;
  sb_item_t sb_q[$];

  logic [15:0] ref_mem [int];
  logic [15:0] sram_mem [int];
  logic [1:0]  cur_mask = '0;
  logic [16:0] cur_addr = '0;
  bit          strobe_seen = 0;
  logic [15:0] last_rd = '0;

  always #5 clk = ~clk;

  sram_byte_ctrl #(
    .ADDR_W (ADDR_W), .LANES (2), .LANE_W (8),
    .ACC_CYC (ACC_CYC), .WP_CYC (WP_CYC), .REC_CYC (REC_CYC)
  ) i_sram_byte_ctrl (
    .clk (clk), .rst (rst),
    .host_req (host_req), .host_write (host_write), .host_addr (host_addr),
    .host_wdata (host_wdata), .host_mask (host_mask),
    .host_rdata (host_rdata), .host_done (host_done),
    .mem_addr (mem_addr), .mem_we_n (mem_we_n), .mem_oe_n (mem_oe_n),
    .mem_lane_en_n (mem_lane_en_n), .mem_dq_out (mem_dq_out),
    .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] sram_rd(input int a);
    return sram_mem.exists(a) ? sram_mem[a] : 16'h0000;
  endfunction

  // Memory model and pin protocol monitor
  int          we_cnt, oe_cnt, rd_cnt, gap_cnt;
  logic [16:0] prev_addr;
  always @(posedge clk) begin
    if (rst) begin
      we_cnt = 0; oe_cnt = 0; rd_cnt = 0; gap_cnt = 100; prev_addr = '0;
    end else begin
      if (!mem_we_n) begin
        logic [15:0] w;
        w = sram_rd(int'(mem_addr));
        if (!mem_lane_en_n[1] && mem_dq_oe[1]) w[15:8] = mem_dq_out[15:8];
        if (!mem_lane_en_n[0] && mem_dq_oe[0]) w[7:0]  = mem_dq_out[7:0];
        sram_mem[int'(mem_addr)] = w;
      end
      if (!mem_we_n || !mem_oe_n || !(&mem_lane_en_n)) strobe_seen = 1;
      if (!mem_we_n) we_cnt++;
      else if (we_cnt != 0) begin
        chk(we_cnt == WP_CYC, "R4 write pulse width", we_cnt, WP_CYC);
        we_cnt = 0;
      end
      if (!mem_oe_n) oe_cnt++;
      else if (oe_cnt != 0) begin
        chk(oe_cnt == ACC_CYC, "R2 read strobe width", oe_cnt, ACC_CYC);
        oe_cnt = 0;
      end
      if (!mem_oe_n && mem_we_n && !(&mem_lane_en_n)) rd_cnt++;
      else rd_cnt = 0;
      if (!mem_we_n || !mem_oe_n || (|mem_dq_oe)) begin
        chk(!(!mem_we_n && !mem_oe_n), "R10 OE/WE overlap", {mem_we_n, mem_oe_n}, 2'b10);
        chk(mem_we_n ? (mem_dq_oe == 2'b00) : (mem_dq_oe == ~mem_lane_en_n),
            "R10 bus drive", mem_dq_oe, mem_we_n ? 2'b00 : ~mem_lane_en_n);
      end
      if (!(&mem_lane_en_n)) begin
        if (gap_cnt != 0)
          chk(gap_cnt >= REC_CYC + 1, "R6 recovery gap", gap_cnt, REC_CYC + 1);
        gap_cnt = 0;
        chk(mem_addr == prev_addr, "R5 address hold", mem_addr, prev_addr);
        chk(mem_addr == cur_addr, "R5 address value", mem_addr, cur_addr);
        chk(mem_lane_en_n == ~cur_mask, "R3 lane enables", mem_lane_en_n, ~cur_mask);
      end else if (mem_we_n) begin
        gap_cnt++;
      end
      prev_addr = mem_addr;
    end
  end

  // Read data returned by the model: garbage until the access time has run.
  always @(negedge clk) begin
    logic [15:0] d;
    logic [15:0] m;
    d = 16'hC3C3;
    m = sram_rd(int'(mem_addr));
    if (!mem_oe_n && mem_we_n) begin
      if (!mem_lane_en_n[1]) d[15:8] = (rd_cnt >= ACC_CYC - 1) ? m[15:8] : 8'hEE;
      if (!mem_lane_en_n[0]) d[7:0]  = (rd_cnt >= ACC_CYC - 1) ? m[7:0]  : 8'hEE;
    end
    mem_dq_in <= d;
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && host_done) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        if (it.is_wr) begin
          chk(host_rdata == last_rd, "R9 rdata held over write", host_rdata, last_rd);
        end else begin
          chk(host_rdata == it.exp, "R2/R3 read data", host_rdata, it.exp);
          last_rd = it.exp;
        end
      end
    end
  end

  task automatic do_op(input bit wr, input logic [16:0] a,
                       input logic [15:0] d, input logic [1:0] m);
    sb_item_t it;
    int lat;
    int n;
    logic [15:0] cur;
    cur = ref_rd(int'(a));
    if (wr) begin
      if (m[1]) cur[15:8] = d[15:8];
      if (m[0]) cur[7:0]  = d[7:0];
      ref_mem[int'(a)] = cur;
      it.exp = 16'h0;
    end else begin
      it.exp = {m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00};
    end
    it.is_wr = wr;
    sb_q.push_back(it);
    n = wr ? WP_CYC : ACC_CYC;
    cur_mask = m; cur_addr = a; strobe_seen = 0;
    host_write = wr; host_addr = a; host_wdata = d; host_mask = m; host_req = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_done && lat < 64);
    host_req = 1'b0;
    chk(lat == n + 2, "R7 done latency", lat, n + 2);
    if (m == 2'b00)
      chk(!strobe_seen, "R8 no strobe on empty mask", strobe_seen, 0);
    @(negedge clk);
    chk(!host_done, "R7 done single cycle", host_done, 0);
    repeat (REC_CYC) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mem_we_n && mem_oe_n, "R1 strobes high", {mem_we_n, mem_oe_n}, 2'b11);
    chk(mem_lane_en_n == 2'b11, "R1 enables high", mem_lane_en_n, 2'b11);
    chk(mem_dq_oe == 2'b00, "R1 bus released", mem_dq_oe, 0);
    chk(!host_done, "R1 done low", host_done, 0);
    chk(host_rdata == 16'h0, "R1 rdata zero", host_rdata, 0);

    // Full-word writes at both address extremes, then reads (R2, R4, R5)
    do_op(1, 17'h00000, 16'h1234, 2'b11);
    do_op(1, 17'h1FFFF, 16'hABCD, 2'b11);
    do_op(0, 17'h00000, 16'h0000, 2'b11);
    do_op(0, 17'h1FFFF, 16'h0000, 2'b11);
    // Lane mapping (R3): upper-only write must not touch the lower byte
    do_op(1, 17'h00000, 16'h55AA, 2'b10);
    do_op(0, 17'h00000, 16'h0000, 2'b01);
    do_op(0, 17'h00000, 16'h0000, 2'b10);
    do_op(1, 17'h1FFFF, 16'hEE77, 2'b01);
    do_op(0, 17'h1FFFF, 16'h0000, 2'b11);
    // Empty mask (R8): no change to memory, read returns zero
    do_op(1, 17'h00000, 16'hFFFF, 2'b00);
    do_op(0, 17'h00000, 16'h0000, 2'b11);
    do_op(0, 17'h00000, 16'h0000, 2'b00);
    // Mixed pattern sweep
    for (int i = 0; i < 12; i++) begin
      logic [16:0] a;
      logic [15:0] d;
      a = 17'((i * 17'h0B3D + 17'h0155) & 17'h1FFFF);
      d = 16'(16'h1F2E ^ (i * 16'h3779));
      do_op(1, a, d, 2'(i % 4));
      do_op(0, a, 16'h0, 2'(3 - (i % 4)));
      do_op(0, a, 16'h0, 2'b11);
    end
    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R7 all requests completed", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule